// File: doc/BRIEF.md
# Exposure and Frame Readout Sequencer

This block sets the timing of an image sensor's frame cycle. It runs on the system clock. A start pulse takes it out of idle. It then exposes for an interval set by a fine and a coarse exposure setting. After that it raises a read strobe and steps a pixel coordinate through a whole frame, one pixel per clock, with the column changing fastest. When the last pixel has gone out, it waits a fixed short gap and begins the next exposure by itself. Frames repeat this way until the active-low reset is asserted.

Both exposure settings are sampled at the clock edge that begins an exposure. The exposure of a frame already under way therefore never changes, even if the settings change while it is exposing or reading. The exposure length in clocks is fine·2^FINE_SHIFT + coarse·2^COARSE_SHIFT. With the default shifts (3 and 11) and a 2 µs clock, this gives 16 µs fine steps and 4.096 ms coarse steps. The frame is COLS × ROWS pixels, where each side is a power of two. The default frame is 128 × 128.

Top module: `expo_readout_seq`

## Requirements
- R1: While rstN is low, exposing, readStrobe and pixelValid are low and colAddr and rowAddr are 0. The reset is asynchronous.
- R2: In idle, a high startIn sampled at a rising clock edge starts a frame. exposing is high in the cycle that follows that edge.
- R3: exposing stays high for exactly fine·2^FINE_SHIFT + coarse·2^COARSE_SHIFT + 1 consecutive cycles. Here fine and coarse are the values sampled at the edge where exposure began.
- R4: Changes to fineIn or coarseIn after that edge have no effect on the exposure length of the current frame.
- R5: readStrobe rises in the first cycle after exposing falls. It stays high for exactly COLS·ROWS consecutive cycles, and pixelValid is high in exactly those cycles.
- R6: During readout the coordinate (colAddr, rowAddr) starts at (0,0), and colAddr increments every cycle. After colAddr = COLS-1 it wraps to 0 and rowAddr increments. The last pixel is (COLS-1, ROWS-1).
- R7: After readStrobe falls, exposing and readStrobe are both low for exactly RESTART_GAP cycles (default 5). exposing then rises without any start pulse, using the fine and coarse values sampled at that edge.
- R8: With fine = coarse = 0, the exposure lasts one cycle and a full frame is still read out.
- R9: startIn is ignored while a frame sequence is running, and the timing of exposure and readout is unchanged.
- R10: colAddr and rowAddr are 0 whenever readStrobe is low.
- R11: Reset asserted in mid-frame returns the block to idle. No exposure begins after reset is released until a new startIn arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse, sampled on the rising edge while idle |
| fineIn | input | FINE_W | Fine exposure setting |
| coarseIn | input | COARSE_W | Coarse exposure setting |
| exposing | output | 1 | High during the exposure interval |
| readStrobe | output | 1 | High while the frame is read out |
| pixelValid | output | 1 | One strobe per pixel output cycle |
| colAddr | output | COL_BITS | Column of the current pixel |
| rowAddr | output | ROW_BITS | Row of the current pixel |

## Verification
The assertions assume that reset is held low from time zero until the first clock edges have passed, and that fineIn and coarseIn are stable around each clock edge. The bench drives every input only on falling clock edges. It changes the exposure settings while a frame is exposing and while it is reading, so the sampling point is exercised without ever breaking setup. It also raises startIn while a frame is busy. The coarse setting is kept small so that the frame loop finishes within the cycle budget.

// File: rtl/expo_seq_pkg.sv
package expo_seq_pkg;

  // Strobes from the control FSM to the datapath counters
  typedef struct packed {
    logic loadExp;   // sample exposure settings into the down-counter
    logic tickExp;   // count exposure down by one
    logic clearPix;  // return pixel coordinate to (0,0)
    logic stepPix;   // advance pixel coordinate, column first
  } seqCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXPOSE = 2'd1,
    ST_READ   = 2'd2,
    ST_GAP    = 2'd3
  } seqState_t;

endpackage

// File: rtl/expo_seq_datapath.sv
module expo_seq_datapath
  import expo_seq_pkg::*;
#(
  parameter int FINE_W       = 8,
  parameter int COARSE_W     = 8,
  parameter int FINE_SHIFT   = 3,
  parameter int COARSE_SHIFT = 11,
  parameter int COL_BITS     = 7,
  parameter int ROW_BITS     = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCmd_t             cmd,
  input  logic [FINE_W-1:0]   fineIn,
  input  logic [COARSE_W-1:0] coarseIn,
  output logic                expZero,
  output logic                pixLast,
  output logic [COL_BITS-1:0] colAddr,
  output logic [ROW_BITS-1:0] rowAddr
);

  localparam int FINE_SPAN   = FINE_W + FINE_SHIFT;
  localparam int COARSE_SPAN = COARSE_W + COARSE_SHIFT;
  localparam int EXP_W       = ((FINE_SPAN > COARSE_SPAN) ? FINE_SPAN : COARSE_SPAN) + 1;
  localparam logic [COL_BITS-1:0] COL_MAX = {COL_BITS{1'b1}};
  localparam logic [ROW_BITS-1:0] ROW_MAX = {ROW_BITS{1'b1}};

  logic [EXP_W-1:0]    expCnt;
  logic [EXP_W-1:0]    fineTerm;
  logic [EXP_W-1:0]    coarseTerm;
  logic [EXP_W-1:0]    expLoad;
  logic [COL_BITS-1:0] colCnt;
  logic [ROW_BITS-1:0] rowCnt;

  // Exposure length in clocks: fine and coarse weighted by their shifts
  always_comb begin
    fineTerm   = EXP_W'(fineIn) << FINE_SHIFT;
    coarseTerm = EXP_W'(coarseIn) << COARSE_SHIFT;
    expLoad    = fineTerm + coarseTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expCnt <= '0;
    end else if (cmd.loadExp) begin
      expCnt <= expLoad;
    end else if (cmd.tickExp && (expCnt != '0)) begin
      expCnt <= expCnt - 1'b1;
    end
  end

  assign expZero = (expCnt == '0);

  // Pixel coordinate: column is the fast index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (cmd.clearPix) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (cmd.stepPix) begin
      colCnt <= colCnt + 1'b1;
      if (colCnt == COL_MAX) begin
        rowCnt <= rowCnt + 1'b1;
      end
    end
  end

  assign pixLast = (colCnt == COL_MAX) && (rowCnt == ROW_MAX);
  assign colAddr = colCnt;
  assign rowAddr = rowCnt;

  // R3: exposure counts down by exactly one per tick
  assert_exp_countdown_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.tickExp && !cmd.loadExp && !expZero) |=> (expCnt == $past(expCnt) - 1'b1));

  // R6: column advances by one while not wrapping
  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepPix && !cmd.clearPix && (colCnt != COL_MAX)) |=>
      (colCnt == $past(colCnt) + 1'b1) && $stable(rowCnt));

  // R6: wrap of column carries into row
  assert_row_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepPix && !cmd.clearPix && (colCnt == COL_MAX)) |=>
      (colCnt == '0) && (rowCnt == $past(rowCnt) + 1'b1));

endmodule

// File: rtl/expo_seq_ctrl.sv
module expo_seq_ctrl
  import expo_seq_pkg::*;
#(
  parameter int RESTART_GAP = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    expZero,
  input  logic    pixLast,
  output seqCmd_t cmd,
  output logic    exposing,
  output logic    reading
);

  localparam int GAP_W = (RESTART_GAP > 1) ? $clog2(RESTART_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(RESTART_GAP - 1);

  seqState_t       state;
  seqState_t       nextState;
  logic [GAP_W-1:0] gapCnt;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startIn) begin
          cmd.loadExp = 1'b1;
          nextState   = ST_EXPOSE;
        end
      end
      ST_EXPOSE: begin
        if (expZero) begin
          cmd.clearPix = 1'b1;
          nextState    = ST_READ;
        end else begin
          cmd.tickExp = 1'b1;
        end
      end
      ST_READ: begin
        if (pixLast) begin
          cmd.clearPix = 1'b1;
          nextState    = ST_GAP;
        end else begin
          cmd.stepPix = 1'b1;
        end
      end
      ST_GAP: begin
        if (gapCnt == '0) begin
          cmd.loadExp = 1'b1;
          nextState   = ST_EXPOSE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_READ) begin
        gapCnt <= GAP_LOAD;
      end else if ((state == ST_GAP) && (gapCnt != '0)) begin
        gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  assign exposing = (state == ST_EXPOSE);
  assign reading  = (state == ST_READ);

  // R5: the two phases never overlap
  assert_phase_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({exposing, reading}));

  // R9: once running, the sequence never falls back to idle without reset
  assert_no_idle_return_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_IDLE));

  // R7: gap expiry starts a new exposure by itself
  assert_auto_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_GAP) && (gapCnt == '0)) |=> exposing);

  // R5: readout follows straight after exposure
  assert_read_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(exposing) |-> reading);

endmodule

// File: rtl/expo_readout_seq.sv
module expo_readout_seq
  import expo_seq_pkg::*;
#(
  parameter int FINE_W       = 8,
  parameter int COARSE_W     = 8,
  parameter int FINE_SHIFT   = 3,
  parameter int COARSE_SHIFT = 11,
  parameter int COL_BITS     = 7,
  parameter int ROW_BITS     = 7,
  parameter int RESTART_GAP  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic [FINE_W-1:0]   fineIn,
  input  logic [COARSE_W-1:0] coarseIn,
  output logic                exposing,
  output logic                readStrobe,
  output logic                pixelValid,
  output logic [COL_BITS-1:0] colAddr,
  output logic [ROW_BITS-1:0] rowAddr
);

  seqCmd_t cmd;
  logic    expZero;
  logic    pixLast;
  logic    reading;

  expo_seq_ctrl #(
    .RESTART_GAP(RESTART_GAP)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .expZero  (expZero),
    .pixLast  (pixLast),
    .cmd      (cmd),
    .exposing (exposing),
    .reading  (reading)
  );

  expo_seq_datapath #(
    .FINE_W      (FINE_W),
    .COARSE_W    (COARSE_W),
    .FINE_SHIFT  (FINE_SHIFT),
    .COARSE_SHIFT(COARSE_SHIFT),
    .COL_BITS    (COL_BITS),
    .ROW_BITS    (ROW_BITS)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .fineIn   (fineIn),
    .coarseIn (coarseIn),
    .expZero  (expZero),
    .pixLast  (pixLast),
    .colAddr  (colAddr),
    .rowAddr  (rowAddr)
  );

  assign readStrobe = reading;
  assign pixelValid = reading;

  // R10: coordinate rests at origin outside readout
  assert_origin_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |-> ((colAddr == '0) && (rowAddr == '0)));

endmodule

// File: tb/expo_readout_seq_test.sv
module expo_readout_seq_test;

  localparam int CB = 3;
  localparam int RB = 2;
  localparam int COLS = 1 << CB;
  localparam int ROWS = 1 << RB;
  localparam int NPIX = COLS * ROWS;
  localparam int GAP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [7:0] fineIn = '0;
  logic [7:0] coarseIn = '0;
  logic exposing, readStrobe, pixelValid;
  logic [CB-1:0] colAddr;
  logic [RB-1:0] rowAddr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  expo_readout_seq #(
    .COL_BITS(CB), .ROW_BITS(RB), .RESTART_GAP(GAP)
  ) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .fineIn(fineIn), .coarseIn(coarseIn),
    .exposing(exposing), .readStrobe(readStrobe), .pixelValid(pixelValid),
    .colAddr(colAddr), .rowAddr(rowAddr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input int f, input int c);
    return f * 8 + c * 2048 + 1;
  endfunction

  // Precondition: at a falling edge where exposing was just seen high for the first time.
  task automatic runFrame(input int f, input int c, input int nf, input int nc,
                          input bit pokeStart, input string tag);
    int n = 0;
    int i = 0;
    int g = 0;
    int badPix = 0;
    int badIdle = 0;
    int firstBad = -1;
    int lastCol = -1;
    int lastRow = -1;
    while (exposing && n < 700000) begin
      if (colAddr != 0 || rowAddr != 0) badIdle++;
      n++;
      if (n == 2) begin
        fineIn = 8'($urandom);
        coarseIn = 8'($urandom);
      end
      if (pokeStart && n == 2) startIn = 1'b1;
      if (pokeStart && n == 3) startIn = 1'b0;
      @(negedge clk);
    end
    startIn = 1'b0;
    check(n == expLen(f, c), {"R3/R4 exposure length ", tag}, n, expLen(f, c));
    check(readStrobe == 1'b1, {"R5 read follows exposure ", tag}, readStrobe, 1);
    while (readStrobe && i < NPIX + 4) begin
      if (i == 3) begin
        fineIn = 8'(nf);
        coarseIn = 8'(nc);
      end
      if (colAddr != (i % COLS) || rowAddr != (i / COLS) || !pixelValid) begin
        badPix++;
        if (firstBad < 0) firstBad = i;
      end
      lastCol = colAddr;
      lastRow = rowAddr;
      i++;
      @(negedge clk);
    end
    check(i == NPIX, {"R5 read length ", tag}, i, NPIX);
    check(badPix == 0, {"R6 pixel order/valid, mismatches ", tag}, badPix, 0);
    check(lastCol == COLS - 1 && lastRow == ROWS - 1, {"R6 last pixel col*100+row ", tag},
          lastCol * 100 + lastRow, (COLS - 1) * 100 + ROWS - 1);
    while (!exposing && !readStrobe && g < 40) begin
      if (colAddr != 0 || rowAddr != 0 || pixelValid) badIdle++;
      g++;
      @(negedge clk);
    end
    check(g == GAP && exposing, {"R7 restart gap ", tag}, g, GAP);
    check(badIdle == 0, {"R10 coordinate at origin outside readout ", tag}, badIdle, 0);
  endtask

  initial begin
    int seedVal;
    int f, c, nf, nc, q;
    seedVal = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!exposing && !readStrobe && !pixelValid, "R1 outputs low in reset",
          {exposing, readStrobe, pixelValid}, 0);
    check(colAddr == 0 && rowAddr == 0, "R1 coordinate zero in reset", {colAddr, rowAddr}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!exposing, "R2 no exposure without start", exposing, 0);

    // R2: start, first frame directed
    f = 5; c = 1;
    fineIn = 8'(f); coarseIn = 8'(c);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(exposing == 1'b1, "R2 exposing after start edge", exposing, 1);
    nf = 0; nc = 0;
    runFrame(f, c, nf, nc, 1'b1, "directed+R9");
    // R8: all-zero exposure frame
    f = nf; c = nc;
    nf = 255; nc = 0;
    runFrame(f, c, nf, nc, 1'b0, "R8 zero exposure");
    f = nf; c = nc;
    // random frames
    for (int k = 0; k < 8; k++) begin
      nf = $urandom_range(0, 255);
      nc = $urandom_range(0, 2);
      runFrame(f, c, nf, nc, (k % 3) == 0, "random");
      f = nf; c = nc;
    end

    // R11: reset in mid-frame
    q = 0;
    while (!readStrobe && q < 20000) begin q++; @(negedge clk); end
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!exposing && !readStrobe && colAddr == 0 && rowAddr == 0, "R11 reset mid-frame",
          {exposing, readStrobe, colAddr, rowAddr}, 0);
    @(negedge clk);
    rstN = 1'b1;
    q = 0;
    for (int k = 0; k < 12000; k++) begin
      if (exposing || readStrobe) q++;
      @(negedge clk);
    end
    check(q == 0, "R11 stays idle after reset release", q, 0);

    // restart after reset works
    f = 3; c = 0;
    fineIn = 8'(f); coarseIn = 8'(c);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(exposing == 1'b1, "R2 restart after reset", exposing, 1);
    runFrame(f, c, 1, 0, 1'b0, "post reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule